// File: doc/BRIEF.md
# Multi-Domain Clock Stop Controller

This block sits between free-running internal clock sources and the clock pins of a system. It has four sources: a processor clock, a memory clock, a peripheral bus clock and a fixed reference clock. From them it drives gated clock outputs. Three active-low requests can halt a group of outputs: processor halt, bus halt and memory halt. An active-low power-down input silences everything. A small bank of per-output enable bits is loaded through a parallel write port in the reference domain. A cleared bit holds its output low whatever the requests are doing.

Each output group is served by its own gating state machine, clocked by that group's source. The states are `GATE_RUN` (gates follow the enable bits), `GATE_HALT` (all gates closed) and `GATE_WAKE` (gates still closed while a restart delay counts down). The transitions are:
- RUN→HALT when a halt request is seen.
- HALT→WAKE when the request clears, in groups with a restart delay.
- HALT→RUN when the request clears, in groups without a restart delay.
- WAKE→HALT if the request returns.
- WAKE→RUN when the delay expires.

Asynchronous requests pass through a two-flop synchronizer in the destination domain. The bus halt request is sampled by a single flop, because it is defined as synchronous to the bus clock. Every gate enable is registered on the falling edge of its source, so an output only opens or closes while its source is low.

Top module: `clkstop_ctrl`

## Requirements
- R1: A halted or disabled output sits at logic 0 and shows no rising edge. Its gate enable is zero on every falling source edge after a cycle in which its state machine was not in `GATE_RUN`.
- R2: Driving `cpu_stop_n` low, at any time with respect to any clock, halts every `cpu_clk_o` output. The memory, bus, free bus and reference outputs keep toggling.
- R3: Once `cpu_stop_n` (and `pwrdn_n`) are high again, the first rising edge of `cpu_clk_o` comes no earlier than 3 processor clock periods later. It does come within 15 periods.
- R4: `pci_stop_n` is sampled on the rising edge of `clk_pci`. When low, it halts all `pci_clk_o` outputs and never halts `pci_free_o`.
- R5: Driving `sdr_stop_n` low halts only `sdr_clk_o`. While both memory requests are inactive, the memory state machine stays in `GATE_RUN`.
- R6: Any mix of the three halt requests may be active together, and each one halts only its own group.
- R7: Driving `pwrdn_n` low outranks the enable bits and the other requests. It holds every output low, `pci_free_o` and `ref_clk_o` included. Releasing it restarts all enabled outputs.
- R8: A write with `cfg_we` high at a rising `clk_ref` edge loads one enable register, bit i mapping to output i, where 1 enables and 0 disables. The register is chosen by `cfg_addr`: 0 for `cpu_clk_o`, 1 for `pci_clk_o` (bits 4:0) with bit 5 for `pci_free_o`, 2 for `sdr_clk_o`, and 3 for `ref_clk_o`. A disabled output stays low after halt requests are released.
- R9: No output high pulse is shorter than half of its source period. Gates open and close only while the source is low.
- R10: While `rst_n` is low, all outputs are low and all enable bits return to 1. After release, every output toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu | input | 1 | Free-running processor clock source |
| clk_sdr | input | 1 | Free-running memory clock source |
| clk_pci | input | 1 | Free-running peripheral bus clock source |
| clk_ref | input | 1 | Free-running reference clock; also clocks the write port |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_stop_n | input | 1 | Asynchronous active-low processor halt request |
| pci_stop_n | input | 1 | Active-low bus halt request, synchronous to clk_pci |
| sdr_stop_n | input | 1 | Asynchronous active-low memory halt request |
| pwrdn_n | input | 1 | Asynchronous active-low power-down |
| cfg_we | input | 1 | Enable register write strobe |
| cfg_addr | input | 2 | Enable register select |
| cfg_wdata | input | CFG_W (13) | Enable register write data |
| cpu_clk_o | output | NCPU (3) | Gated processor clocks |
| pci_clk_o | output | NPCI (5) | Gated bus clocks |
| pci_free_o | output | 1 | Bus clock halted only by power-down or its enable bit |
| sdr_clk_o | output | NSDR (13) | Gated memory clocks |
| ref_clk_o | output | NREF (3) | Gated reference clocks |

## Verification
The halt function is tried in several ways:
- Each request alone, which shows that a request reaches only its own group.
- Pairs and the full set of requests together, which separates independent gating from any cross-coupling between groups.
- Power-down while the enables are all ones, which shows that it outranks everything, including the free bus clock.
- Mixed enable patterns (sparse processor bits, a checkerboard on the memory bits, the free bus bit cleared), which catch bit-order and register-select mistakes and show that a disabled output stays dark after a halt is released.

Requests are also changed at instants unrelated to any clock edge. Meanwhile, every high pulse is measured against half its source period, and the processor restart delay is timed from release to the first edge.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

    typedef enum logic [1:0] {
        GATE_RUN  = 2'd0,
        GATE_HALT = 2'd1,
        GATE_WAKE = 2'd2
    } gate_state_t;

    localparam logic [1:0] SEL_CPU = 2'd0;
    localparam logic [1:0] SEL_PCI = 2'd1;
    localparam logic [1:0] SEL_SDR = 2'd2;
    localparam logic [1:0] SEL_REF = 2'd3;

endpackage

// File: rtl/cs_sync.sv
module cs_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/cs_cfg_bank.sv
module cs_cfg_bank
    import clkstop_pkg::*;
#(
    parameter int NCPU  = 3,
    parameter int NPCI  = 5,
    parameter int NSDR  = 13,
    parameter int NREF  = 3,
    parameter int CFG_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [1:0]       addr,
    input  logic [CFG_W-1:0] wdata,
    output logic [NCPU-1:0]  cpu_mask,
    output logic [NPCI-1:0]  pci_mask,
    output logic             free_en,
    output logic [NSDR-1:0]  sdr_mask,
    output logic [NREF-1:0]  ref_mask
);
    logic [NPCI:0] pci_reg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_mask <= '1;
            pci_reg  <= '1;
            sdr_mask <= '1;
            ref_mask <= '1;
        end else if (we) begin
            unique case (addr)
                SEL_CPU: cpu_mask <= wdata[NCPU-1:0];
                SEL_PCI: pci_reg  <= wdata[NPCI:0];
                SEL_SDR: sdr_mask <= wdata[NSDR-1:0];
                SEL_REF: ref_mask <= wdata[NREF-1:0];
            endcase
        end
    end

    assign pci_mask = pci_reg[NPCI-1:0];
    assign free_en  = pci_reg[NPCI];

    logic unused_wbits;
    assign unused_wbits = ^wdata;
endmodule

// File: rtl/cs_domain_gate.sv
module cs_domain_gate
    import clkstop_pkg::*;
#(
    parameter int NOUT     = 1,
    parameter int SYNC_N   = 2,
    parameter int WAKE_CYC = 0
) (
    input  logic            clk_src,
    input  logic            rst_n,
    input  logic            halt_async,
    input  logic            halt_sync,
    input  logic [NOUT-1:0] mask_async,
    output logic [NOUT-1:0] clk_out
);
    localparam int CW = (WAKE_CYC > 1) ? $clog2(WAKE_CYC) : 1;
    localparam logic [CW-1:0] WAKE_LAST = CW'((WAKE_CYC > 0) ? WAKE_CYC - 1 : 0);

    gate_state_t     state_q, state_d;
    logic            halt_a_s, halt_s_q, halt;
    logic [NOUT-1:0] mask_s, gate_next, en_q;
    logic [CW-1:0]   wake_cnt;

    cs_sync #(.W(1), .STAGES(SYNC_N), .RST_VAL(1'b0)) u_halt_sync (
        .clk(clk_src), .rst_n(rst_n), .d(halt_async), .q(halt_a_s)
    );

    cs_sync #(.W(NOUT), .STAGES(SYNC_N), .RST_VAL({NOUT{1'b1}})) u_mask_sync (
        .clk(clk_src), .rst_n(rst_n), .d(mask_async), .q(mask_s)
    );

    always_ff @(posedge clk_src or negedge rst_n) begin
        if (!rst_n) halt_s_q <= 1'b0;
        else        halt_s_q <= halt_sync;
    end

    assign halt = halt_a_s | halt_s_q;

    // state register
    always_ff @(posedge clk_src or negedge rst_n) begin
        if (!rst_n) state_q <= GATE_RUN;
        else        state_q <= state_d;
    end

    // restart delay counter
    always_ff @(posedge clk_src or negedge rst_n) begin
        if (!rst_n)                  wake_cnt <= '0;
        else if (state_q != GATE_WAKE) wake_cnt <= '0;
        else                         wake_cnt <= wake_cnt + 1'b1;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_RUN:  if (halt) state_d = GATE_HALT;
            GATE_HALT: if (!halt) state_d = (WAKE_CYC == 0) ? GATE_RUN : GATE_WAKE;
            GATE_WAKE: begin
                if (halt)                        state_d = GATE_HALT;
                else if (wake_cnt == WAKE_LAST)  state_d = GATE_RUN;
            end
            default:   state_d = GATE_HALT;
        endcase
    end

    // outputs: gates open only in RUN, filtered by the enable bits
    always_comb begin
        gate_next = '0;
        unique case (state_q)
            GATE_RUN:  gate_next = mask_s;
            GATE_HALT: gate_next = '0;
            GATE_WAKE: gate_next = '0;
            default:   gate_next = '0;
        endcase
    end

    // enables move only on the falling edge, while the source is low
    always_ff @(negedge clk_src or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= gate_next;
    end

    for (genvar g = 0; g < NOUT; g++) begin : g_gate
        assign clk_out[g] = clk_src & en_q[g];
    end
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
    import clkstop_pkg::*;
#(
    parameter int NCPU     = 3,
    parameter int NPCI     = 5,
    parameter int NSDR     = 13,
    parameter int NREF     = 3,
    parameter int SYNC_N   = 2,
    parameter int CPU_WAKE = 3,
    localparam int W_A     = (NCPU > NPCI + 1) ? NCPU : NPCI + 1,
    localparam int W_B     = (NSDR > NREF) ? NSDR : NREF,
    localparam int CFG_W   = (W_A > W_B) ? W_A : W_B
) (
    input  logic             clk_cpu,
    input  logic             clk_sdr,
    input  logic             clk_pci,
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic             cpu_stop_n,
    input  logic             pci_stop_n,
    input  logic             sdr_stop_n,
    input  logic             pwrdn_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [NCPU-1:0]  cpu_clk_o,
    output logic [NPCI-1:0]  pci_clk_o,
    output logic             pci_free_o,
    output logic [NSDR-1:0]  sdr_clk_o,
    output logic [NREF-1:0]  ref_clk_o
);
    logic [NCPU-1:0] cpu_mask;
    logic [NPCI-1:0] pci_mask;
    logic            free_en;
    logic [NSDR-1:0] sdr_mask;
    logic [NREF-1:0] ref_mask;
    logic            pd_req;

    assign pd_req = ~pwrdn_n;

    cs_cfg_bank #(
        .NCPU(NCPU), .NPCI(NPCI), .NSDR(NSDR), .NREF(NREF), .CFG_W(CFG_W)
    ) u_cfg (
        .clk(clk_ref), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .cpu_mask(cpu_mask), .pci_mask(pci_mask), .free_en(free_en),
        .sdr_mask(sdr_mask), .ref_mask(ref_mask)
    );

    cs_domain_gate #(.NOUT(NCPU), .SYNC_N(SYNC_N), .WAKE_CYC(CPU_WAKE)) u_cpu (
        .clk_src(clk_cpu), .rst_n(rst_n),
        .halt_async(pd_req | ~cpu_stop_n), .halt_sync(1'b0),
        .mask_async(cpu_mask), .clk_out(cpu_clk_o)
    );

    cs_domain_gate #(.NOUT(NPCI), .SYNC_N(SYNC_N), .WAKE_CYC(0)) u_pci (
        .clk_src(clk_pci), .rst_n(rst_n),
        .halt_async(pd_req), .halt_sync(~pci_stop_n),
        .mask_async(pci_mask), .clk_out(pci_clk_o)
    );

    cs_domain_gate #(.NOUT(1), .SYNC_N(SYNC_N), .WAKE_CYC(0)) u_free (
        .clk_src(clk_pci), .rst_n(rst_n),
        .halt_async(pd_req), .halt_sync(1'b0),
        .mask_async(free_en), .clk_out(pci_free_o)
    );

    cs_domain_gate #(.NOUT(NSDR), .SYNC_N(SYNC_N), .WAKE_CYC(0)) u_sdr (
        .clk_src(clk_sdr), .rst_n(rst_n),
        .halt_async(pd_req | ~sdr_stop_n), .halt_sync(1'b0),
        .mask_async(sdr_mask), .clk_out(sdr_clk_o)
    );

    cs_domain_gate #(.NOUT(NREF), .SYNC_N(SYNC_N), .WAKE_CYC(0)) u_ref (
        .clk_src(clk_ref), .rst_n(rst_n),
        .halt_async(pd_req), .halt_sync(1'b0),
        .mask_async(ref_mask), .clk_out(ref_clk_o)
    );
endmodule

// File: rtl/clkstop_ctrl_chk.sv
module clkstop_ctrl_chk
    import clkstop_pkg::*;
#(
    parameter int NCPU = 3
) (
    input logic            clk_cpu,
    input logic            clk_sdr,
    input logic            clk_pci,
    input logic            clk_ref,
    input logic            rst_n,
    input logic            cpu_stop_n,
    input logic            pci_stop_n,
    input logic            sdr_stop_n,
    input logic            pwrdn_n,
    input gate_state_t     cpu_state,
    input gate_state_t     pci_state,
    input gate_state_t     free_state,
    input gate_state_t     sdr_state,
    input gate_state_t     ref_state,
    input logic [NCPU-1:0] cpu_en
);
    // R1
    cpu_gate_closed_chk: assert property (@(negedge clk_cpu) disable iff (!rst_n)
        ($past(cpu_state) != GATE_RUN) |-> (cpu_en == '0));

    // R3
    cpu_wake_delay_chk: assert property (@(posedge clk_cpu) disable iff (!rst_n)
        $rose(cpu_state == GATE_RUN) |->
            ($past(cpu_stop_n && pwrdn_n, 1) && $past(cpu_stop_n && pwrdn_n, 2)
             && $past(cpu_stop_n && pwrdn_n, 3)));

    // R4
    pci_sync_halt_chk: assert property (@(posedge clk_pci) disable iff (!rst_n)
        (!$past(pci_stop_n, 2) && !$past(pci_stop_n, 1)) |-> (pci_state == GATE_HALT));

    // R4
    free_runs_chk: assert property (@(posedge clk_pci) disable iff (!rst_n)
        (pwrdn_n && $past(pwrdn_n, 1) && $past(pwrdn_n, 2) && $past(pwrdn_n, 3)
         && $past(pwrdn_n, 4)) |-> (free_state == GATE_RUN));

    // R5
    sdr_local_chk: assert property (@(posedge clk_sdr) disable iff (!rst_n)
        ((sdr_stop_n && pwrdn_n) && $past(sdr_stop_n && pwrdn_n, 1)
         && $past(sdr_stop_n && pwrdn_n, 2) && $past(sdr_stop_n && pwrdn_n, 3)
         && $past(sdr_stop_n && pwrdn_n, 4)) |-> (sdr_state == GATE_RUN));

    // R7
    pd_ref_halt_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (!pwrdn_n && !$past(pwrdn_n, 1) && !$past(pwrdn_n, 2) && !$past(pwrdn_n, 3)
         && !$past(pwrdn_n, 4)) |-> (ref_state != GATE_RUN));
endmodule

bind clkstop_ctrl clkstop_ctrl_chk #(.NCPU(NCPU)) u_chk (
    .clk_cpu(clk_cpu), .clk_sdr(clk_sdr), .clk_pci(clk_pci), .clk_ref(clk_ref),
    .rst_n(rst_n), .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n),
    .sdr_stop_n(sdr_stop_n), .pwrdn_n(pwrdn_n),
    .cpu_state(u_cpu.state_q), .pci_state(u_pci.state_q), .free_state(u_free.state_q),
    .sdr_state(u_sdr.state_q), .ref_state(u_ref.state_q), .cpu_en(u_cpu.en_q)
);

// File: tb/sim_clkstop_ctrl.sv
`timescale 1ns/1ps

module pulse_watch #(
    parameter int  N    = 1,
    parameter real HALF = 4.0
) (
    input  logic [N-1:0] sig,
    input  logic         clr,
    output logic [N-1:0] seen,
    output logic [N-1:0] bad
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        real  t_rise;
        logic armed, s_b, b_b;
        initial begin
            t_rise = 0.0; armed = 1'b0; s_b = 1'b0; b_b = 1'b0;
        end
        always @(posedge sig[i] or posedge clr) begin
            if (clr) s_b = 1'b0;
            else begin
                s_b = 1'b1; armed = 1'b1; t_rise = $realtime;
            end
        end
        always @(negedge sig[i]) begin
            if (armed && ($realtime - t_rise < HALF * 0.98)) b_b = 1'b1;
        end
        assign seen[i] = s_b;
        assign bad[i]  = b_b;
    end
endmodule

module sim_clkstop_ctrl;
    localparam int NCPU = 3, NPCI = 5, NSDR = 13, NREF = 3, CFG_W = 13;

    logic clk_cpu = 0, clk_sdr = 0, clk_pci = 0, clk_ref = 0;
    logic rst_n = 0, cpu_stop_n = 1, pci_stop_n = 1, sdr_stop_n = 1, pwrdn_n = 1;
    logic cfg_we = 0;
    logic [1:0] cfg_addr = '0;
    logic [CFG_W-1:0] cfg_wdata = '0;
    logic [NCPU-1:0] cpu_clk_o;
    logic [NPCI-1:0] pci_clk_o;
    logic            pci_free_o;
    logic [NSDR-1:0] sdr_clk_o;
    logic [NREF-1:0] ref_clk_o;

    always #4  clk_cpu = ~clk_cpu;
    always #5  clk_sdr = ~clk_sdr;
    always #15 clk_pci = ~clk_pci;
    always #35 clk_ref = ~clk_ref;

    clkstop_ctrl u0 (
        .clk_cpu(clk_cpu), .clk_sdr(clk_sdr), .clk_pci(clk_pci), .clk_ref(clk_ref),
        .rst_n(rst_n), .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n),
        .sdr_stop_n(sdr_stop_n), .pwrdn_n(pwrdn_n), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cpu_clk_o(cpu_clk_o),
        .pci_clk_o(pci_clk_o), .pci_free_o(pci_free_o), .sdr_clk_o(sdr_clk_o),
        .ref_clk_o(ref_clk_o)
    );

    logic clr = 0;
    logic [NCPU-1:0] cpu_seen, cpu_bad;
    logic [NPCI-1:0] pci_seen, pci_bad;
    logic [0:0]      free_seen, free_bad;
    logic [NSDR-1:0] sdr_seen, sdr_bad;
    logic [NREF-1:0] ref_seen, ref_bad;

    pulse_watch #(.N(NCPU), .HALF(4.0))  w_cpu (.sig(cpu_clk_o), .clr(clr), .seen(cpu_seen), .bad(cpu_bad));
    pulse_watch #(.N(NPCI), .HALF(15.0)) w_pci (.sig(pci_clk_o), .clr(clr), .seen(pci_seen), .bad(pci_bad));
    pulse_watch #(.N(1),    .HALF(15.0)) w_fre (.sig(pci_free_o), .clr(clr), .seen(free_seen), .bad(free_bad));
    pulse_watch #(.N(NSDR), .HALF(5.0))  w_sdr (.sig(sdr_clk_o), .clr(clr), .seen(sdr_seen), .bad(sdr_bad));
    pulse_watch #(.N(NREF), .HALF(35.0)) w_ref (.sig(ref_clk_o), .clr(clr), .seen(ref_seen), .bad(ref_bad));

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic observe(input int len);
        clr = 1; #1; clr = 0;
        #(len);
    endtask

    task automatic chk_groups(input string req, input logic [NCPU-1:0] c,
                              input logic [NPCI-1:0] p, input logic f,
                              input logic [NSDR-1:0] s, input logic [NREF-1:0] r);
        chk(cpu_seen == c,     req, "cpu edges",  32'(cpu_seen),  32'(c));
        chk(pci_seen == p,     req, "pci edges",  32'(pci_seen),  32'(p));
        chk(free_seen[0] == f, req, "free edges", 32'(free_seen), 32'(f));
        chk(sdr_seen == s,     req, "sdr edges",  32'(sdr_seen),  32'(s));
        chk(ref_seen == r,     req, "ref edges",  32'(ref_seen),  32'(r));
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [CFG_W-1:0] d);
        @(negedge clk_ref);
        cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk_ref);
        cfg_we = 0;
        #400;
    endtask

    task automatic t_reset;
        #3;
        chk({cpu_clk_o, pci_clk_o, pci_free_o, sdr_clk_o, ref_clk_o} == '0, "R10",
            "outputs in reset", 32'(cpu_clk_o), 0);
        #100.3; rst_n = 1;
        #400; observe(600);
        chk_groups("R10", '1, '1, 1'b1, '1, '1);
    endtask

    task automatic t_cpu_halt;
        real t0;
        bit  hit;
        #3.3; cpu_stop_n = 0;
        #100; observe(500);
        chk_groups("R2", '0, '1, 1'b1, '1, '1);
        chk(cpu_clk_o == '0, "R1", "cpu level while halted", 32'(cpu_clk_o), 0);
        #2.7; cpu_stop_n = 1; t0 = $realtime; hit = 0;
        for (int k = 0; k < 400 && !hit; k++) begin
            #0.5;
            if (cpu_clk_o[0]) hit = 1;
        end
        chk(hit && ($realtime - t0 >= 24.0) && ($realtime - t0 <= 120.0), "R3",
            "release-to-edge ns", 32'($rtoi($realtime - t0)), 24);
    endtask

    task automatic t_pci_halt;
        @(posedge clk_pci); #2; pci_stop_n = 0;
        #200; observe(500);
        chk_groups("R4", '1, '0, 1'b1, '1, '1);
        @(posedge clk_pci); #2; pci_stop_n = 1;
        #200; observe(300);
        chk(pci_seen == '1, "R4", "pci restart", 32'(pci_seen), 32'h1f);
    endtask

    task automatic t_sdr_halt;
        #6.1; sdr_stop_n = 0;
        #100; observe(500);
        chk_groups("R5", '1, '1, 1'b1, '0, '1);
        #1.9; sdr_stop_n = 1;
        #100; observe(300);
        chk(sdr_seen == '1, "R5", "sdr restart", 32'(sdr_seen), 32'h1fff);
    endtask

    task automatic t_combo;
        #2.2; cpu_stop_n = 0; sdr_stop_n = 0;
        #200; observe(500);
        chk_groups("R6", '0, '1, 1'b1, '0, '1);
        @(posedge clk_pci); #2; pci_stop_n = 0;
        #200; observe(500);
        chk_groups("R6", '0, '0, 1'b1, '0, '1);
        cpu_stop_n = 1; sdr_stop_n = 1;
        @(posedge clk_pci); #2; pci_stop_n = 1;
        #300; observe(500);
        chk_groups("R6", '1, '1, 1'b1, '1, '1);
    endtask

    task automatic t_pwrdn;
        #7.3; pwrdn_n = 0;
        #400; observe(600);
        chk_groups("R7", '0, '0, 1'b0, '0, '0);
        chk({cpu_clk_o, pci_clk_o, pci_free_o, sdr_clk_o, ref_clk_o} == '0, "R7",
            "levels in power-down", 32'(ref_clk_o), 0);
        #3.1; pwrdn_n = 1;
        #400; observe(600);
        chk_groups("R7", '1, '1, 1'b1, '1, '1);
    endtask

    task automatic t_cfg;
        cfg_write(2'd0, 13'b101);
        cfg_write(2'd2, 13'h1555);
        observe(500);
        chk_groups("R8", 3'b101, '1, 1'b1, 13'h1555, '1);
        cfg_write(2'd1, 13'b01_1111);
        cfg_write(2'd3, 13'd0);
        observe(600);
        chk_groups("R8", 3'b101, '1, 1'b0, 13'h1555, '0);
        #1.3; cpu_stop_n = 0; #200; cpu_stop_n = 1;
        #200; observe(400);
        chk(cpu_seen == 3'b101, "R8", "disabled after release", 32'(cpu_seen), 5);
        chk(cpu_clk_o[1] == 1'b0, "R8", "disabled level", 32'(cpu_clk_o[1]), 0);
        cfg_write(2'd0, '1); cfg_write(2'd1, '1);
        cfg_write(2'd2, '1); cfg_write(2'd3, '1);
        observe(600);
        chk_groups("R8", '1, '1, 1'b1, '1, '1);
    endtask

    initial begin
        t_reset();
        t_cpu_halt();
        t_pci_halt();
        t_sdr_halt();
        t_combo();
        t_pwrdn();
        t_cfg();
        chk({cpu_bad, pci_bad, free_bad, sdr_bad, ref_bad} == '0, "R9",
            "short high pulses", 32'(sdr_bad), 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule